// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the fetch address of a small fixed-point signal-processing core and decides its next value on every clock. A three-bit control code from the instruction decoder tells it to step on, to jump, to call, to return or to enter an interrupt. A call or interrupt entry saves a return address on a six-entry hardware stack, and a return takes the newest saved address back into the counter.

A reset request may arrive at any time. It passes through a two-flop synchroniser. On the first synchronised reset cycle the counter value in use at that moment is saved on the stack, the same as an interrupt entry. The counter then sits at the fixed start address 0x0FFC until the request is withdrawn, and a status-clear strobe is high for that whole time. Stack contents and the stack position survive a reset. An active-low hold input freezes the counter and marks the cycle as a no-operation.

The stack never blocks. Saving into a full stack drops the oldest entry. Taking from an empty stack returns the entry taken most recently. Each of these cases raises a one-cycle flag.

Top module: `pc_sequencer`

## Requirements
- R1: With `halt_n` high and no reset, code 0 (step) loads `pc_o` with the previous value plus one, modulo 2^13, so 0x1FFF is followed by 0x0000.
- R2: Code 1 (jump) loads `target_i` into `pc_o` and leaves the stack unchanged.
- R3: Code 2 (call) saves the current `pc_o` plus one on the stack and loads `target_i`. Code 3 (return) loads the newest saved entry and removes it. Returns come back in reverse order of the calls.
- R4: Code 4 (interrupt entry) saves the current `pc_o` itself, not advanced, and loads `target_i`.
- R5: The stack keeps six entries. A save made when six are held discards the oldest entry and pulses `ovf_o` high for one cycle. This applies to the save made by reset as well.
- R6: A return from an empty stack loads the entry most recently removed, leaves the stack empty and pulses `unf_o` high for one cycle. Before anything has been removed, that entry is 0.
- R7: `rst_in` acts after two synchroniser stages. On the first synchronised reset edge, the current `pc_o` is saved on the stack and `pc_o` becomes 0x0FFC. It stays 0x0FFC while reset lasts, and it advances from 0x0FFC on the third edge after `rst_in` falls. Reset takes priority over `halt_n`.
- R8: `stat_clr_o` is high exactly in the cycles in which `pc_o` is being held at the start address by the synchronised reset.
- R9: A reset does not erase earlier stack entries. After a reset, returns give back the value saved by the reset, followed by the entries saved before it.
- R10: While `halt_n` is low and no reset is active, `pc_o` keeps its value and `nop_o` is high one edge later. Every control code is ignored: no save, no removal, no flag.
- R11: Codes 5, 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset request, active high, may be asynchronous |
| halt_n | input | 1 | Hold request, active low |
| op_i | input | 3 | Control code: 0 step, 1 jump, 2 call, 3 return, 4 interrupt entry |
| target_i | input | 13 | Jump, call or interrupt destination |
| pc_o | output | 13 | Current program fetch address |
| nop_o | output | 1 | The cycle is held as a no-operation |
| stat_clr_o | output | 1 | Status register clear strobe |
| ovf_o | output | 1 | One-cycle pulse: a save dropped the oldest entry |
| unf_o | output | 1 | One-cycle pulse: a return found the stack empty |

## Verification
The bench runs nested-depth sweeps. For every depth from zero to eight it makes that many calls, with steps between them, and then one return more than the number of calls. This separates correct LIFO order from an off-by-one pointer, and it shows where the overflow and underflow cases begin. Jumps to the end of the address space, interrupt entries and the unused codes show whether the saved address is advanced or not, and whether wrap-around is modular. Resets applied over a partly filled stack and over a full stack tell a retained stack from a cleared one, and show whether the reset save counts as a push. Holds with every code applied show that nothing leaks through the freeze.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_NEXT = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_INTR = 3'd4
  } seq_op_e;
endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_sync_o
);
  // Plain flop chain; power-up value 0 so no reset appears at start-up.
  logic [STAGES-1:0] chain_q = '0;

  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-2:0], rst_in};
  end

  assign rst_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int DW    = 13,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] pop_data_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Storage, position and fill count keep their values across reset.
  logic [DW-1:0] mem_q [DEPTH] = '{default: '0};
  logic [PW-1:0] top_q = '0;
  logic [CW-1:0] cnt_q = '0;
  logic          ovf_q = 1'b0;
  logic          unf_q = 1'b0;

  logic [PW-1:0] above_idx;
  logic [PW-1:0] below_idx;
  logic          full;
  logic          empty;

  assign above_idx = (top_q == LAST_IDX) ? '0 : top_q + 1'b1;
  assign below_idx = (top_q == '0) ? LAST_IDX : top_q - 1'b1;
  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);

  // When empty, the slot above the top holds the entry removed last.
  assign pop_data_o = empty ? mem_q[above_idx] : mem_q[top_q];

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem_q[above_idx] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    ovf_q <= 1'b0;
    unf_q <= 1'b0;
    if (push_i) begin
      top_q <= above_idx;
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop_i) begin
      if (empty) begin
        unf_q <= 1'b1;
      end else begin
        top_q <= below_idx;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int              PC_W        = 13,
  parameter int              STACK_DEPTH = 6,
  parameter int              SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] RESET_VEC   = PC_W'(12'hFFC)
) (
  input  logic            clk,
  input  logic            rst_in,
  input  logic            halt_n,
  input  logic [2:0]      op_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic            nop_o,
  output logic            stat_clr_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic            rst_s;
  logic            rst_d_q = 1'b0;
  logic [PC_W-1:0] pc_q    = '0;
  logic            nop_q   = 1'b0;
  logic            clr_q   = 1'b0;

  logic            rst_edge;
  logic            run;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] pop_data;
  logic [PC_W-1:0] pc_d;

  pc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_in    (rst_in),
    .rst_sync_o(rst_s)
  );

  assign rst_edge = rst_s & ~rst_d_q;
  assign run      = ~rst_s & halt_n;
  assign pc_inc   = pc_q + 1'b1;

  always_comb begin
    push      = rst_edge;
    pop       = 1'b0;
    push_data = pc_q;
    if (run) begin
      case (op_i)
        OP_CALL: begin
          push      = 1'b1;
          push_data = pc_inc;
        end
        OP_INTR: push = 1'b1;
        OP_RET:  pop  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (rst_s) begin
      pc_d = RESET_VEC;
    end else if (!halt_n) begin
      pc_d = pc_q;
    end else begin
      case (op_i)
        OP_JUMP, OP_CALL, OP_INTR: pc_d = target_i;
        OP_RET:                    pc_d = pop_data;
        default:                   pc_d = pc_inc;
      endcase
    end
  end

  pc_ret_stack #(.DW(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk        (clk),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(push_data),
    .pop_data_o (pop_data),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  always_ff @(posedge clk) begin
    rst_d_q <= rst_s;
    pc_q    <= pc_d;
    clr_q   <= rst_s;
    nop_q   <= ~rst_s & ~halt_n;
  end

  assign pc_o       = pc_q;
  assign nop_o      = nop_q;
  assign stat_clr_o = clr_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int              PC_W      = 13,
  parameter logic [PC_W-1:0] RESET_VEC = PC_W'(12'hFFC)
) (
  input logic            clk,
  input logic            rst_s,
  input logic            halt_n,
  input logic [2:0]      op_i,
  input logic [PC_W-1:0] target_i,
  input logic [PC_W-1:0] pc_o,
  input logic            nop_o,
  input logic            stat_clr_o,
  input logic            ovf_o,
  input logic            unf_o
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc_o + 1'b1;

  assert_step_R1: assert property (@(posedge clk) disable iff (rst_s)
    (halt_n && (op_i == 3'd0 || op_i > 3'd4)) |=> pc_o == $past(pc_inc));

  assert_jump_R2: assert property (@(posedge clk) disable iff (rst_s)
    (halt_n && op_i == 3'd1) |=> pc_o == $past(target_i));

  assert_flags_exclusive_R5: assert property (@(posedge clk)
    !(ovf_o && unf_o));

  assert_reset_vector_R8: assert property (@(posedge clk)
    stat_clr_o |-> pc_o == RESET_VEC);

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst_s)
    !halt_n |=> ($stable(pc_o) && nop_o && !unf_o));
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .halt_n    (halt_n),
  .op_i      (op_i),
  .target_i  (target_i),
  .pc_o      (pc_o),
  .nop_o     (nop_o),
  .stat_clr_o(stat_clr_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  localparam int PCW  = 13;
  localparam int MASK = (1 << PCW) - 1;
  localparam int VEC  = 'h0FFC;
  localparam int CAP  = 6;

  logic           clk = 1'b0;
  logic           rst_in = 1'b0;
  logic           halt_n = 1'b1;
  logic [2:0]     op_i = 3'd0;
  logic [PCW-1:0] target_i = '0;
  logic [PCW-1:0] pc_o;
  logic           nop_o, stat_clr_o, ovf_o, unf_o;

  int total = 0;
  int bad   = 0;
  int m_pc  = 0;
  int stk[$];
  int last_pop = 0;
  int e_ovf, e_unf;
  int pop_val;

  always #2.5 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst_in(rst_in), .halt_n(halt_n), .op_i(op_i),
    .target_i(target_i), .pc_o(pc_o), .nop_o(nop_o),
    .stat_clr_o(stat_clr_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_push(input int v);
    if (stk.size() == CAP) begin
      void'(stk.pop_front());
      e_ovf = 1;
    end
    stk.push_back(v & MASK);
  endtask

  task automatic m_pop();
    if (stk.size() == 0) begin
      e_unf = 1;
      pop_val = last_pop;
    end else begin
      pop_val = stk.pop_back();
      last_pop = pop_val;
    end
  endtask

  // Entered just after a negedge; returns at the next negedge.
  task automatic step(input int op, input int tgt, input string req);
    op_i = op[2:0];
    target_i = tgt[PCW-1:0];
    e_ovf = 0; e_unf = 0;
    case (op)
      1: m_pc = tgt;
      2: begin m_push(m_pc + 1); m_pc = tgt; end
      3: begin m_pop(); m_pc = pop_val; end
      4: begin m_push(m_pc); m_pc = tgt; end
      default: m_pc = (m_pc + 1) & MASK;
    endcase
    @(posedge clk); #1;
    chk(req, pc_o, m_pc);
    chk({req, " ovf R5"}, ovf_o, e_ovf);
    chk({req, " unf R6"}, unf_o, e_unf);
    chk({req, " nop"}, nop_o, 0);
    @(negedge clk);
    op_i = 3'd0;
  endtask

  task automatic step_halt(input int op, input int tgt);
    halt_n = 1'b0;
    op_i = op[2:0];
    target_i = tgt[PCW-1:0];
    @(posedge clk); #1;
    chk("R10 halt pc frozen", pc_o, m_pc);
    chk("R10 halt nop", nop_o, 1);
    chk("R10 halt no ovf", ovf_o, 0);
    chk("R10 halt no unf", unf_o, 0);
    @(negedge clk);
    op_i = 3'd0;
    halt_n = 1'b1;
  endtask

  task automatic do_reset(input int hold, input logic hold_halt);
    op_i = 3'd0;
    rst_in = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      m_pc = (m_pc + 1) & MASK;
    end
    halt_n = ~hold_halt;
    e_ovf = 0;
    m_push(m_pc);
    m_pc = VEC;
    @(posedge clk); #1;
    chk("R7 pc at vector", pc_o, VEC);
    chk("R8 clear strobe", stat_clr_o, 1);
    chk("R5 reset save ovf", ovf_o, e_ovf);
    chk("R7 no nop in reset", nop_o, 0);
    for (int k = 1; k < hold; k++) begin
      @(posedge clk); #1;
      chk("R7 pc held", pc_o, VEC);
      chk("R5 single reset save", ovf_o, 0);
    end
    rst_in = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      chk("R7 held after release", pc_o, VEC);
      chk("R8 strobe after release", stat_clr_o, 1);
    end
    halt_n = 1'b1;
    @(posedge clk); #1;
    m_pc = (VEC + 1) & MASK;
    chk("R7 advance from vector", pc_o, m_pc);
    chk("R8 strobe off", stat_clr_o, 0);
    @(negedge clk);
  endtask

  initial begin
    #1;
    do_reset(3, 1'b0);

    // Nested-depth sweep: n calls, then n+1 returns.
    for (int n = 0; n <= 8; n++) begin
      for (int i = 0; i < n; i++) begin
        step(2, ('h100 + 37 * i + 5 * n) & MASK, "R3 call");
        step(0, 0, "R1 step");
      end
      for (int i = 0; i <= n; i++) begin
        step(3, 0, "R3 R6 return");
      end
    end

    // Jumps and wrap-around.
    for (int t = 0; t < 8; t++) begin
      step(1, (t * 1171) & MASK, "R2 jump");
      step(0, 0, "R1 step after jump");
    end
    step(1, MASK, "R2 jump end");
    step(0, 0, "R1 wrap to zero");

    // Interrupt entry saves the unadvanced address.
    step(1, 'h0A0, "R2 jump");
    step(4, 'h010, "R4 interrupt entry");
    step(0, 0, "R1 step in handler");
    step(3, 0, "R4 return to interrupted address");

    // Unused codes behave as step.
    for (int c = 5; c < 8; c++) step(c, 'h1234, "R11 unused code");

    // Hold with every code applied, then show the stack untouched.
    step(2, 'h300, "R3 call before hold");
    for (int c = 0; c < 8; c++) step_halt(c, 'h055);
    step(0, 0, "R10 resume step");
    step(3, 0, "R10 stack intact after hold");

    // Reset over a partly filled stack keeps the entries.
    step(2, 'h400, "R3 call");
    step(2, 'h500, "R3 call");
    do_reset(4, 1'b1);
    for (int i = 0; i < 4; i++) step(3, 0, "R9 return after reset");

    // Reset over a full stack drops the oldest entry.
    for (int i = 0; i < 6; i++) step(2, 'h600 + i, "R5 fill");
    do_reset(2, 1'b0);
    for (int i = 0; i < 7; i++) step(3, 0, "R5 R9 drain");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule